// File: doc/BRIEF.md
# ADC Sample Trigger Scheduler

This block decides when each of 19 converter sample slots asks for a conversion. Every slot holds a small configuration word: which event starts it, which edges of the external start pin count, and an optional delay measured in ticks of a prescaled converter clock. Events come from a software start mask, the external start pin, two end-of-conversion pulses, four timer overflow pulses and fourteen PWM trigger lines.

A triggered slot raises a pending bit, either at once or when its delay expires. The scheduler hands pending slots one at a time to a converter through a start pulse and a slot number, then waits for the converter's done pulse. That pulse clears the slot's pending bit. Software can cancel pending requests with a mask. A trigger that reaches a slot which is already pending, or still counting its delay, is dropped. It sets that slot's overrun flag instead, and a summary output shows whether any overrun flag is set.

Top module: `adc_trig_sched`

## Requirements
- R1: After reset, `pending`, `ovf_sts`, `ovf_any`, `busy` and `conv_start` are all 0, and every slot's configuration word is 0.
- R2: A cycle with `swtrg_we` high triggers every slot whose bit is set in `swtrg_mask`, whatever its source code. A slot with delay 0 shows its `pending` bit after the next rising edge.
- R3: Source code (config bits [4:0]) 0 means no hardware event. Codes 2 and 3 select `eoc_pulse[0]` and `eoc_pulse[1]`. Codes 4 to 7 select `tmr_ovf[0]` to `tmr_ovf[3]`. Codes 8 to 21 select `pwm_trg[0]` to `pwm_trg[13]`. Codes 22 to 31 never trigger. A selected input that is high in a cycle is an event in that cycle.
- R4: Source code 1 selects the external pin. The pin passes through two synchronising flops and is then compared with its previous synchronised value. Config bit 5 enables falling edges and bit 6 enables rising edges, and both may be set. With delay 0, `pending` rises after the third rising edge that follows the pin change.
- R5: Config bits [8:7] pick the delay tick: code 0 is every cycle, code 1 is a cycle where prescaler bit 0 is 1, code 2 is a cycle where prescaler bits [1:0] are 3, and code 3 is a cycle where the prescaler is 15. The prescaler is a 4-bit counter that is 0 in the first cycle after reset and counts up by 1 each cycle. With a nonzero delay D (config bits [16:9]), `pending` is set at the end of the cycle that holds the D-th tick after the event cycle.
- R6: While `busy` is low and any pending bit is not being cancelled in the same cycle, the lowest-numbered such slot is granted. In the next cycle `conv_start` is high for one cycle, `conv_module` holds the slot number, and `busy` rises. Only one slot is granted at a time.
- R7: `conv_done` while `busy` is high clears the granted slot's pending bit and lowers `busy` after that edge. `conv_module` stays stable while `busy` is high.
- R8: A `cancel_we` cycle clears the `pending` bits selected by `cancel_mask`. It also aborts their delay countdowns. A cancel beats a set in the same cycle.
- R9: An event for a slot that is pending or counting its delay sets that slot's `ovf_sts` bit, and the event is otherwise dropped. An `ovf_clr_we` cycle clears the bits selected by `ovf_clr_mask`. A set beats a clear in the same cycle.
- R10: `ovf_any` is 1 exactly when any `ovf_sts` bit is 1.
- R11: `cfg_we` loads `cfg_data` into slot `cfg_idx` when the index is 0 to 18. Other index values change nothing. Events seen in the write cycle still use the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Slot to configure |
| cfg_data | input | 17 | {delay[7:0], tick code[1:0], rise enable, fall enable, source[4:0]} |
| swtrg_we | input | 1 | Software trigger strobe |
| swtrg_mask | input | 19 | Slots to trigger |
| cancel_we | input | 1 | Cancel strobe |
| cancel_mask | input | 19 | Slots whose requests are cancelled |
| ovf_clr_we | input | 1 | Overrun clear strobe |
| ovf_clr_mask | input | 19 | Overrun flags to clear |
| ext_pin | input | 1 | Asynchronous external start pin |
| eoc_pulse | input | 2 | End-of-conversion event pulses |
| tmr_ovf | input | 4 | Timer overflow pulses |
| pwm_trg | input | 14 | PWM trigger pulses |
| conv_done | input | 1 | Converter finished the granted slot |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_module | output | 5 | Granted slot number |
| busy | output | 1 | A conversion is granted and not yet done |
| pending | output | 19 | Per-slot pending requests |
| ovf_sts | output | 19 | Per-slot event overrun flags |
| ovf_any | output | 1 | Any overrun flag set |

## Verification
The assertions assume that `conv_done` arrives only while `busy` is high, and that it comes at least one cycle after `conv_start`. They also assume the pulse inputs are synchronous to `clk`, while `ext_pin` may change at any time. The bench keeps to this with a behavioural converter. That converter arms only on an observed `conv_start` and pulses done a fixed number of cycles later, and it can be stalled to hold `busy`. All stimulus changes on the falling clock edge. Only `ext_pin` relies on the synchroniser.

// File: rtl/adc_trig_sched.sv
module adc_trig_sched #(
  parameter int NMOD = 19,
  parameter int IDXW = 5,
  parameter int DLYW = 8,
  parameter int NEOC = 2,
  parameter int NTMR = 4,
  parameter int NPWM = 14,
  localparam int SRCW = 5,
  localparam int CFGW = DLYW + SRCW + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [CFGW-1:0] cfg_data,
  input  logic            swtrg_we,
  input  logic [NMOD-1:0] swtrg_mask,
  input  logic            cancel_we,
  input  logic [NMOD-1:0] cancel_mask,
  input  logic            ovf_clr_we,
  input  logic [NMOD-1:0] ovf_clr_mask,
  input  logic            ext_pin,
  input  logic [NEOC-1:0] eoc_pulse,
  input  logic [NTMR-1:0] tmr_ovf,
  input  logic [NPWM-1:0] pwm_trg,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [IDXW-1:0] conv_module,
  output logic            busy,
  output logic [NMOD-1:0] pending,
  output logic [NMOD-1:0] ovf_sts,
  output logic            ovf_any
);
  localparam int NCODE = 1 << SRCW;
  localparam int NHW   = 2 + NEOC + NTMR + NPWM;

  logic [2:0]      ext_s;
  logic [3:0]      psc_q;
  logic [NMOD-1:0] pend_q, ovf_q, set_v, ovfset_v, cancel_v, cand, done_clr;
  logic            gnt_ok;
  logic [IDXW-1:0] gnt_idx;

  wire ext_rise = ext_s[1] & ~ext_s[2];
  wire ext_fall = ~ext_s[1] & ext_s[2];
  wire [3:0] tick = {psc_q == 4'hF, psc_q[1:0] == 2'b11, psc_q[0], 1'b1};
  wire [NCODE-1:0] hwv = {{(NCODE-NHW){1'b0}}, pwm_trg, tmr_ovf, eoc_pulse, 2'b00};

  assign cancel_v = cancel_we ? cancel_mask : '0;
  assign cand     = pend_q & ~cancel_v;
  assign done_clr = (busy & conv_done) ? (NMOD'(1) << conv_module) : '0;
  assign pending  = pend_q;
  assign ovf_sts  = ovf_q;
  assign ovf_any  = |ovf_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_s <= '0;
      psc_q <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_pin};
      psc_q <= psc_q + 4'd1;
    end

  for (genvar g = 0; g < NMOD; g++) begin : g_mod
    logic [SRCW-1:0] src;
    logic            fe, re, act;
    logic [1:0]      div;
    logic [DLYW-1:0] dly, cnt;

    wire hw   = (src == SRCW'(1)) ? ((fe & ext_fall) | (re & ext_rise)) : hwv[src];
    wire ev   = (swtrg_we & swtrg_mask[g]) | hw;
    wire occ  = pend_q[g] | act;
    wire take = ev & ~occ;
    wire fin  = act & tick[div] & (cnt == DLYW'(1));

    assign set_v[g]    = (take & (dly == '0)) | fin;
    assign ovfset_v[g] = ev & occ;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) {dly, div, re, fe, src} <= '0;
      else if (cfg_we && cfg_idx == IDXW'(g)) {dly, div, re, fe, src} <= cfg_data;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        act <= 1'b0;
        cnt <= '0;
      end else if (cancel_v[g]) begin
        act <= 1'b0;
      end else if (take && dly != '0) begin
        act <= 1'b1;
        cnt <= dly;
      end else if (fin) begin
        act <= 1'b0;
      end else if (act && tick[div]) begin
        cnt <= cnt - DLYW'(1);
      end
  end

  always_comb begin
    gnt_ok  = 1'b0;
    gnt_idx = '0;
    for (int i = NMOD - 1; i >= 0; i--)
      if (cand[i]) begin
        gnt_ok  = 1'b1;
        gnt_idx = IDXW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q      <= '0;
      ovf_q       <= '0;
      busy        <= 1'b0;
      conv_start  <= 1'b0;
      conv_module <= '0;
    end else begin
      pend_q     <= ((pend_q & ~done_clr) | set_v) & ~cancel_v;
      ovf_q      <= (ovf_q & ~(ovf_clr_we ? ovf_clr_mask : '0)) | ovfset_v;
      conv_start <= 1'b0;
      if (!busy && gnt_ok) begin
        busy        <= 1'b1;
        conv_start  <= 1'b1;
        conv_module <= gnt_idx;
      end else if (busy && conv_done) begin
        busy <= 1'b0;
      end
    end
endmodule

module adc_trig_sched_chk #(
  parameter int NMOD = 19,
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_done,
  input logic            conv_start,
  input logic [IDXW-1:0] conv_module,
  input logic            busy,
  input logic [NMOD-1:0] pending,
  input logic [NMOD-1:0] ovf_sts,
  input logic            ovf_any
);
  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R6
  start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> pending[conv_module]);
  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && conv_done |=> !busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> busy && $stable(conv_module));
  // R10
  ovf_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sts != '0) |-> ovf_any);
endmodule

bind adc_trig_sched adc_trig_sched_chk #(.NMOD(NMOD), .IDXW(IDXW)) u_chk (.*);

// File: tb/tb_adc_trig_sched.sv
module tb_adc_trig_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N = 19;
  localparam int LAT = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [4:0] cfg_idx = 0; logic [16:0] cfg_data = 0;
  logic swtrg_we = 0; logic [N-1:0] swtrg_mask = 0;
  logic cancel_we = 0; logic [N-1:0] cancel_mask = 0;
  logic ovf_clr_we = 0; logic [N-1:0] ovf_clr_mask = 0;
  logic ext_pin = 0; logic [1:0] eoc_pulse = 0; logic [3:0] tmr_ovf = 0;
  logic [13:0] pwm_trg = 0; logic conv_done = 0;
  logic conv_start, busy, ovf_any; logic [4:0] conv_module;
  logic [N-1:0] pending, ovf_sts;

  adc_trig_sched dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, ctm = 0;
  bit auto_done = 1;

  bit [N-1:0] m_pend, m_ovf, m_act;
  int m_cnt[N], m_src[N], m_div[N], m_dly[N];
  bit m_fe[N], m_re[N];
  bit m_busy, m_start; int m_mod; int psc; bit q1, q2, q3;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_ovf = 0; m_act = 0; m_busy = 0; m_start = 0; m_mod = 0;
      psc = 0; q1 = 0; q2 = 0; q3 = 0;
      for (int i = 0; i < N; i++) begin
        m_cnt[i] = 0; m_src[i] = 0; m_div[i] = 0; m_dly[i] = 0; m_fe[i] = 0; m_re[i] = 0;
      end
    end else begin
      bit tk[4]; bit rise, fall; bit [N-1:0] np, no, na; int g;
      tk[0] = 1; tk[1] = (psc % 2) == 1; tk[2] = (psc % 4) == 3; tk[3] = psc == 15;
      rise = q2 && !q3; fall = !q2 && q3;
      np = m_pend; na = m_act;
      no = m_ovf & ~(ovf_clr_we ? ovf_clr_mask : '0);
      if (m_busy && conv_done) np[m_mod] = 0;
      g = -1;
      if (!m_busy)
        for (int i = N - 1; i >= 0; i--)
          if (m_pend[i] && !(cancel_we && cancel_mask[i])) g = i;
      for (int i = 0; i < N; i++) begin
        bit hw, ev, occ, take, fin, canc; int s;
        s = m_src[i];
        if (s == 1) hw = (m_fe[i] && fall) || (m_re[i] && rise);
        else if (s == 2 || s == 3) hw = eoc_pulse[s-2];
        else if (s >= 4 && s <= 7) hw = tmr_ovf[s-4];
        else if (s >= 8 && s <= 21) hw = pwm_trg[s-8];
        else hw = 0;
        ev = (swtrg_we && swtrg_mask[i]) || hw;
        occ = m_pend[i] || m_act[i];
        canc = cancel_we && cancel_mask[i];
        if (ev && occ) no[i] = 1;
        take = ev && !occ;
        fin = m_act[i] && tk[m_div[i]] && m_cnt[i] == 1;
        if ((take && m_dly[i] == 0) || fin) np[i] = 1;
        if (canc) begin np[i] = 0; na[i] = 0; end
        else if (take && m_dly[i] != 0) begin na[i] = 1; m_cnt[i] = m_dly[i]; end
        else if (fin) na[i] = 0;
        else if (m_act[i] && tk[m_div[i]]) m_cnt[i]--;
      end
      m_start = 0;
      if (!m_busy && g >= 0) begin m_start = 1; m_busy = 1; m_mod = g; end
      else if (m_busy && conv_done) m_busy = 0;
      if (cfg_we && cfg_idx < N) begin
        m_src[cfg_idx] = cfg_data[4:0]; m_fe[cfg_idx] = cfg_data[5];
        m_re[cfg_idx] = cfg_data[6]; m_div[cfg_idx] = cfg_data[8:7];
        m_dly[cfg_idx] = cfg_data[16:9];
      end
      m_pend = np; m_ovf = no; m_act = na;
      q3 = q2; q2 = q1; q1 = ext_pin;
      psc = (psc + 1) % 16;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 pending", 32'(pending), 32'(m_pend));
      chk("R9 ovf_sts", 32'(ovf_sts), 32'(m_ovf));
      chk("R10 ovf_any", 32'(ovf_any), 32'(m_ovf != 0));
      chk("R6 busy", 32'(busy), 32'(m_busy));
      chk("R6 conv_start", 32'(conv_start), 32'(m_start));
      if (m_start) chk("R6 conv_module", 32'(conv_module), 32'(m_mod));
    end
    conv_done = 0;
    if (conv_start) ctm = LAT;
    else if (auto_done && ctm > 0) begin
      ctm--;
      if (ctm == 0) conv_done = 1;
    end
    if (cyc > 150000) begin
      nfail++; nchk++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int idx, int src, bit fe, bit re, int dv, int dl);
    cfg_we = 1; cfg_idx = 5'(idx); cfg_data = {8'(dl), 2'(dv), re, fe, 5'(src)};
    step(); cfg_we = 0;
  endtask

  task automatic sw(logic [N-1:0] m);
    swtrg_we = 1; swtrg_mask = m; step(); swtrg_we = 0; swtrg_mask = 0;
  endtask

  initial begin
    step(3);
    chk("R1 pending", 32'(pending), 0);
    chk("R1 ovf", 32'(ovf_sts), 0);
    chk("R1 busy/start", {30'd0, busy, conv_start}, 0);
    rst_n = 1;
    step(2);
    chk("R1 idle after release", 32'(pending), 0);

    sw(19'h00005);
    chk("R2 pending after sw", 32'(pending), 32'(m_pend));
    step(20);

    cfg(3, 4, 0, 0, 0, 0); cfg(5, 2, 0, 0, 0, 0); cfg(7, 21, 0, 0, 0, 0);
    cfg(8, 31, 0, 0, 0, 0); cfg(9, 0, 0, 0, 0, 0);
    tmr_ovf = 4'hF; eoc_pulse = 2'b11; pwm_trg = '1; step();
    tmr_ovf = 0; eoc_pulse = 0; pwm_trg = 0;
    chk("R3 hw sources", 32'(pending & 19'h00BA8), 32'(19'h000A8));
    step(30);
    pwm_trg = 14'h2000; step(); pwm_trg = 0;
    chk("R3 pwm13 only", 32'(pending[7]), 1);
    step(20);

    cfg(10, 1, 0, 1, 0, 0); cfg(11, 1, 1, 0, 0, 0); cfg(12, 1, 1, 1, 0, 0);
    ext_pin = 1; step(3);
    chk("R4 rising edge", 32'(pending[12:10] | 3'b000), 32'(m_pend[12:10]));
    chk("R4 rising sets 10/12", 32'(m_pend[12:10]), 32'(3'b101));
    step(20);
    ext_pin = 0; step(3);
    chk("R4 falling edge", 32'(pending[12:10]), 32'(m_pend[12:10]));
    step(20);

    cfg(13, 0, 0, 0, 2, 3); cfg(14, 0, 0, 0, 3, 2); cfg(15, 0, 0, 0, 1, 1);
    sw(19'h0E000);
    step(2);
    chk("R5 not yet pending", 32'(pending[14:13]), 0);
    step(60);
    chk("R5 delays done", 32'(pending), 32'(m_pend));

    auto_done = 0;
    sw(19'h00001); step(2);
    sw(19'h30000); step();
    cancel_we = 1; cancel_mask = 19'h10000; step(); cancel_we = 0; cancel_mask = 0;
    chk("R8 cancelled", 32'(pending[16]), 0);
    sw(19'h20000); step();
    chk("R9 overrun 17", 32'(ovf_sts[17]), 1);
    chk("R10 summary", 32'(ovf_any), 1);
    ovf_clr_we = 1; ovf_clr_mask = 19'h20000; step(); ovf_clr_we = 0; ovf_clr_mask = 0;
    chk("R9 cleared", 32'(ovf_sts[17]), 0);
    auto_done = 1;
    step(40);

    cfg(25, 5, 0, 0, 0, 0);
    tmr_ovf = 4'b0010; step(); tmr_ovf = 0;
    chk("R11 bad index ignored", 32'(pending), 0);
    step(5);

    for (int k = 0; k < 6000; k++) begin
      swtrg_we = ($urandom % 8) == 0; swtrg_mask = N'($urandom);
      cancel_we = ($urandom % 16) == 0; cancel_mask = N'($urandom);
      ovf_clr_we = ($urandom % 16) == 0; ovf_clr_mask = N'($urandom);
      eoc_pulse = 2'(($urandom % 6 == 0) ? $urandom : 0);
      tmr_ovf = 4'(($urandom % 6 == 0) ? $urandom : 0);
      pwm_trg = 14'(($urandom % 4 == 0) ? $urandom : 0);
      if ($urandom % 10 == 0) ext_pin = ~ext_pin;
      cfg_we = ($urandom % 20) == 0; cfg_idx = 5'($urandom);
      cfg_data = {8'($urandom % 6), 2'($urandom), 7'($urandom % 24)};
      step();
    end
    swtrg_we = 0; cancel_we = 0; ovf_clr_we = 0; cfg_we = 0;
    eoc_pulse = 0; tmr_ovf = 0; pwm_trg = 0;
    step(200);
    chk("R7 drained", 32'(busy), 32'(m_busy));
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule